// File: doc/BRIEF.md
# Bank Reconfiguration Invalidation Sweeper

After software rewrites the mapping that spreads a share's lines over the banks of a distributed last-level cache, some lines already in a bank are stored in the wrong place. This block is started once per remap. It walks every line slot of its local bank and reads the tag of each slot. For each valid line it asks the external mapping logic which bank now owns that line's address for the line's share. Lines that still belong to this bank are left alone. Lines that now belong elsewhere are invalidated. A dirty line is first handed to the writeback path, and the sweeper waits for that handoff to be acknowledged before it invalidates the line.

No directory is kept. After one full sweep, every line that remains in the bank sits in the only bank its address now maps to. Remaps are rare, so the sweep runs at one slot per clock and stops only for writebacks. The tag array read port has one cycle of latency. The mapping lookup is combinational and is answered in the same cycle.

Top module: `reconfig_inval_walker`

## Requirements
- R1: A start pulse seen while idle begins a sweep, and busy is high from the next cycle until the sweep ends.
- R2: Slots are read once each, in increasing linear index, where index = set*WAYS + way (way in the low bits). The read set and way ports carry the two fields of that index.
- R3: While no writeback is pending, a new slot read is issued every cycle.
- R4: A slot whose valid bit is clear raises no mapping lookup, no tag write and no writeback.
- R5: A valid line whose looked-up home bank equals local_bank_i is left valid.
- R6: A valid clean line whose home bank differs from local_bank_i is invalidated through the tag write port, with no writeback.
- R7: A valid dirty line whose home bank differs raises wb_req_o with wb_line_o = {tag, set}. Request and address hold steady until wb_ack_i. No slot is read and nothing is invalidated while the request is open. The line is invalidated in the cycle the ack arrives.
- R8: At the end of a sweep, done_o is high for exactly one cycle, and the block then returns to idle with busy low.
- R9: A start pulse during a sweep has no effect: one done pulse and an unchanged sweep length.
- R10: After reset the block is idle, and busy, done, both tag ports, the lookup and the writeback request are all low.
- R11: A sweep keeps busy high for LINES+3 cycles. Each writeback adds the number of cycles wb_req_o is high, plus one more cycle unless the written-back slot is the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sweep (honoured when idle) |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| tag_rd_en_o | output | 1 | Tag array read strobe |
| tag_rd_set_o | output | log2(SETS) | Set index being read |
| tag_rd_way_o | output | log2(WAYS) | Way index being read |
| rd_valid_i | input | 1 | Valid bit of slot read last cycle |
| rd_dirty_i | input | 1 | Dirty bit of slot read last cycle |
| rd_tag_i | input | TAG_W | Tag of slot read last cycle |
| rd_share_i | input | SHARE_W | Share id of slot read last cycle |
| tag_wr_en_o | output | 1 | Clear the valid bit of the addressed slot |
| tag_wr_set_o | output | log2(SETS) | Set of slot to invalidate |
| tag_wr_way_o | output | log2(WAYS) | Way of slot to invalidate |
| map_req_o | output | 1 | Mapping lookup in use this cycle |
| map_line_o | output | TAG_W+log2(SETS) | Line address {tag, set} to map |
| map_share_o | output | SHARE_W | Share id to map |
| map_bank_i | input | BANK_W | Home bank returned by the mapping |
| local_bank_i | input | BANK_W | Identity of this bank |
| wb_req_o | output | 1 | Writeback request for a moving dirty line |
| wb_line_o | output | TAG_W+log2(SETS) | Line address of the writeback |
| wb_ack_i | input | 1 | Writeback accepted |

## Verification
A corrupted read cursor or read pipeline shows at the read ports within one cycle as a skipped or repeated index. By the end of the sweep it also shows as a wrong valid bit in the bank, because the wrong slot was judged. A wrong decision leaves a line valid, clears one that should stay, or adds or drops a writeback. The writeback log and the final bank contents expose that as soon as the sweep finishes. Stall or state errors change the number of busy cycles or the done pulse, and both are compared to a figure derived from the line count and the ack delay.

// File: rtl/rinv_pkg.sv
package rinv_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SWEEP,
        W_FLUSH,
        W_FINISH
    } walk_state_e;

    typedef struct packed {
        logic inval;   // line must leave this bank
        logic flush;   // leaving line is dirty: write back first
    } verdict_t;

    function automatic verdict_t judge_line(input logic valid,
                                            input logic dirty,
                                            input logic home_local);
        verdict_t v;
        v.inval = valid && !home_local;
        v.flush = valid && !home_local && dirty;
        return v;
    endfunction

endpackage

// File: rtl/rinv_cursor.sv
module rinv_cursor #(
    parameter int LINES = 64,
    localparam int CNT_W = $clog2(LINES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             exhausted
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assign exhausted = (count == CNT_W'(LINES));

    // R2: never step past the last slot
    p_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> !exhausted);

endmodule

// File: rtl/rinv_judge.sv
module rinv_judge
    import rinv_pkg::*;
(
    input  logic     valid,
    input  logic     dirty,
    input  logic     home_local,
    output verdict_t verdict
);
    always_comb begin
        verdict = judge_line(valid, dirty, home_local);
    end
endmodule

// File: rtl/reconfig_inval_walker.sv
module reconfig_inval_walker
    import rinv_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 6,
    parameter int SHARE_W = 3,
    parameter int BANK_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start_i,
    output logic                            busy_o,
    output logic                            done_o,
    output logic                            tag_rd_en_o,
    output logic [$clog2(SETS)-1:0]         tag_rd_set_o,
    output logic [$clog2(WAYS)-1:0]         tag_rd_way_o,
    input  logic                            rd_valid_i,
    input  logic                            rd_dirty_i,
    input  logic [TAG_W-1:0]                rd_tag_i,
    input  logic [SHARE_W-1:0]              rd_share_i,
    output logic                            tag_wr_en_o,
    output logic [$clog2(SETS)-1:0]         tag_wr_set_o,
    output logic [$clog2(WAYS)-1:0]         tag_wr_way_o,
    output logic                            map_req_o,
    output logic [TAG_W+$clog2(SETS)-1:0]   map_line_o,
    output logic [SHARE_W-1:0]              map_share_o,
    input  logic [BANK_W-1:0]               map_bank_i,
    input  logic [BANK_W-1:0]               local_bank_i,
    output logic                            wb_req_o,
    output logic [TAG_W+$clog2(SETS)-1:0]   wb_line_o,
    input  logic                            wb_ack_i
);
    localparam int LINES  = SETS * WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int IDX_W  = SET_W + WAY_W;
    localparam int LINE_W = TAG_W + SET_W;
    localparam int CNT_W  = IDX_W + 1;

    walk_state_e         state;
    logic                pend_v;
    logic [IDX_W-1:0]    pend_idx;
    logic [IDX_W-1:0]    hold_idx;
    logic [LINE_W-1:0]   hold_line;
    logic [CNT_W-1:0]    cur_count;
    logic                cur_end;
    logic                start_go;
    logic                issue;
    logic                looking;
    logic                home_local;
    logic                stall;
    logic [LINE_W-1:0]   eval_line;
    logic [IDX_W-1:0]    wr_idx;
    verdict_t            verdict;

    assign start_go = (state == W_IDLE) && start_i;

    rinv_cursor #(.LINES(LINES)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_go),
        .step      (issue),
        .count     (cur_count),
        .exhausted (cur_end)
    );

    // evaluation stage: tag data of the slot read one cycle ago
    assign looking    = (state == W_SWEEP) && pend_v;
    assign eval_line  = {rd_tag_i, pend_idx[IDX_W-1:WAY_W]};
    assign home_local = (map_bank_i == local_bank_i);

    rinv_judge u_judge (
        .valid      (looking && rd_valid_i),
        .dirty      (rd_dirty_i),
        .home_local (home_local),
        .verdict    (verdict)
    );

    assign stall = verdict.flush;
    assign issue = (state == W_SWEEP) && !stall && !cur_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            pend_v    <= 1'b0;
            pend_idx  <= '0;
            hold_idx  <= '0;
            hold_line <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    pend_v <= 1'b0;
                    if (start_i) state <= W_SWEEP;
                end
                W_SWEEP: begin
                    if (stall) begin
                        hold_idx  <= pend_idx;
                        hold_line <= eval_line;
                        pend_v    <= 1'b0;
                        state     <= W_FLUSH;
                    end else begin
                        pend_v   <= issue;
                        pend_idx <= cur_count[IDX_W-1:0];
                        if (!pend_v && cur_end) state <= W_FINISH;
                    end
                end
                W_FLUSH: begin
                    if (wb_ack_i) state <= W_SWEEP;
                end
                W_FINISH: state <= W_IDLE;
                default:  state <= W_IDLE;
            endcase
        end
    end

    assign tag_rd_en_o  = issue;
    assign tag_rd_set_o = cur_count[IDX_W-1:WAY_W];
    assign tag_rd_way_o = cur_count[WAY_W-1:0];

    assign map_req_o   = looking && rd_valid_i;
    assign map_line_o  = eval_line;
    assign map_share_o = rd_share_i;

    assign wr_idx       = (state == W_FLUSH) ? hold_idx : pend_idx;
    assign tag_wr_en_o  = ((state == W_SWEEP) && verdict.inval && !verdict.flush) ||
                          ((state == W_FLUSH) && wb_ack_i);
    assign tag_wr_set_o = wr_idx[IDX_W-1:WAY_W];
    assign tag_wr_way_o = wr_idx[WAY_W-1:0];

    assign wb_req_o  = (state == W_FLUSH);
    assign wb_line_o = hold_line;

    assign busy_o = (state != W_IDLE);
    assign done_o = (state == W_FINISH);

    // R1: accepted start makes the block busy next cycle
    p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R2: back-to-back reads step the linear index by one
    p_read_order_r2: assert property (@(posedge clk) disable iff (rst)
        (tag_rd_en_o && $past(tag_rd_en_o)) |->
        ({tag_rd_set_o, tag_rd_way_o} == $past({tag_rd_set_o, tag_rd_way_o}) + 1'b1));

    // R4: mapping is consulted only for valid slots
    p_no_lookup_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        map_req_o |-> rd_valid_i);

    // R7: open writeback holds its address and blocks reads and invalidates
    p_flush_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_line_o)));
    p_no_read_in_flush_r7: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> !tag_rd_en_o);
    p_no_inval_before_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && !wb_ack_i) |-> !tag_wr_en_o);

    // R8: single done pulse, then idle and quiet
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!tag_rd_en_o && !tag_wr_en_o && !wb_req_o && !map_req_o));

endmodule

// File: tb/reconfig_inval_walker_bench.sv
`timescale 1ns/1ps
module reconfig_inval_walker_bench;
    localparam int SETS = 16, WAYS = 4, TAG_W = 6, SHARE_W = 3, BANK_W = 2;
    localparam int LINES = SETS * WAYS;
    localparam int LINE_W = TAG_W + 4;
    localparam logic [BANK_W-1:0] LOCAL = 2'd2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, done, rd_en, wr_en, map_req, wb_req;
    logic [3:0] rd_set, wr_set;
    logic [1:0] rd_way, wr_way;
    logic rd_v, rd_d;
    logic [TAG_W-1:0] rd_t;
    logic [SHARE_W-1:0] rd_s, map_s;
    logic [LINE_W-1:0] map_line, wb_line;
    logic [BANK_W-1:0] map_bank;
    logic wb_ack;

    always #4 clk = ~clk;

    reconfig_inval_walker u_reconfig_inval_walker (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
        .tag_rd_en_o(rd_en), .tag_rd_set_o(rd_set), .tag_rd_way_o(rd_way),
        .rd_valid_i(rd_v), .rd_dirty_i(rd_d), .rd_tag_i(rd_t), .rd_share_i(rd_s),
        .tag_wr_en_o(wr_en), .tag_wr_set_o(wr_set), .tag_wr_way_o(wr_way),
        .map_req_o(map_req), .map_line_o(map_line), .map_share_o(map_s),
        .map_bank_i(map_bank), .local_bank_i(LOCAL),
        .wb_req_o(wb_req), .wb_line_o(wb_line), .wb_ack_i(wb_ack));

    // bank contents and expectations
    logic m_v [LINES];
    logic m_d [LINES];
    logic [TAG_W-1:0] m_t [LINES];
    logic [SHARE_W-1:0] m_s [LINES];
    logic [LINE_W-1:0] exp_wb [LINES];
    logic [LINE_W-1:0] got_wb [LINES];
    int exp_wb_n, got_wb_n, ack_delay, ack_cnt;
    int busy_cyc, done_cyc, rd_seen, order_err, lookup_err, req_cyc;
    int checks = 0, fails = 0;

    function automatic logic [BANK_W-1:0] home(input logic [LINE_W-1:0] line,
                                               input logic [SHARE_W-1:0] sh);
        logic [LINE_W-1:0] t;
        t = line ^ (line >> 4);
        return t[1:0] + sh[1:0] + {1'b0, sh[2]};
    endfunction

    assign map_bank = home(map_line, map_s);

    // tag array model with one-cycle read latency
    always @(posedge clk) begin
        if (rd_en) begin
            rd_v <= m_v[{rd_set, rd_way}];
            rd_d <= m_d[{rd_set, rd_way}];
            rd_t <= m_t[{rd_set, rd_way}];
            rd_s <= m_s[{rd_set, rd_way}];
        end
        if (wr_en) m_v[{wr_set, wr_way}] <= 1'b0;
    end

    // writeback acceptor with programmable wait
    always @(posedge clk) begin
        if (rst) begin
            wb_ack <= 1'b0; ack_cnt <= 0;
        end else if (wb_req && !wb_ack) begin
            if (ack_cnt == ack_delay) begin
                wb_ack <= 1'b1; ack_cnt <= 0;
            end else ack_cnt <= ack_cnt + 1;
        end else wb_ack <= 1'b0;
    end

    // port monitors
    always @(posedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc <= busy_cyc + 1;
            if (done) done_cyc <= done_cyc + 1;
            if (wb_req) req_cyc <= req_cyc + 1;
            if (rd_en) begin
                if (int'({rd_set, rd_way}) != rd_seen) order_err <= order_err + 1;
                rd_seen <= rd_seen + 1;
            end
            if (map_req && !rd_v) lookup_err <= lookup_err + 1;
            if (wb_req && wb_ack) begin
                got_wb[got_wb_n] <= wb_line;
                got_wb_n <= got_wb_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] line_of(input int i);
        return {m_t[i], 4'(i / WAYS)};
    endfunction

    // mode 0 all invalid, 1 all valid clean, 2 mixed, 3 all stay home
    task automatic sweep(input int seed, input int mode, input int delay, input bit restart);
        bit keep [LINES];
        int flushes, exp_busy;
        bit last_flush;
        ack_delay = delay;
        exp_wb_n = 0; flushes = 0; last_flush = 0;
        for (int i = 0; i < LINES; i++) begin
            m_v[i] = (mode == 0) ? 1'b0 : (mode == 2) ? (((i * 5 + seed) % 3) != 0) : 1'b1;
            m_d[i] = (mode == 1) ? 1'b0 : (((i * 3 + seed) % 4) == 1);
            m_t[i] = TAG_W'((i * 11 + seed * 7) % 64);
            m_s[i] = SHARE_W'((i + seed) % 8);
            if (mode == 3) begin
                for (int s = 0; s < 8; s++)
                    if (home(line_of(i), m_s[i]) != LOCAL) m_s[i] = SHARE_W'(s + 1);
            end
            if (mode == 2 && i == LINES - 1) begin
                m_v[i] = 1'b1; m_d[i] = 1'b1;
                if (home(line_of(i), m_s[i]) == LOCAL) m_s[i] = m_s[i] + 1'b1;
            end
        end
        for (int i = 0; i < LINES; i++) begin
            keep[i] = m_v[i] && (home(line_of(i), m_s[i]) == LOCAL);
            if (m_v[i] && !keep[i] && m_d[i]) begin
                exp_wb[exp_wb_n] = line_of(i);
                exp_wb_n++; flushes++;
                if (i == LINES - 1) last_flush = 1;
            end
        end
        busy_cyc = 0; done_cyc = 0; rd_seen = 0; order_err = 0;
        lookup_err = 0; req_cyc = 0; got_wb_n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        if (restart) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done_cyc == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 idle after done", int'(busy), 0);
        chk(done_cyc == 1, "R8 R9 single done pulse", done_cyc, 1);
        chk(order_err == 0 && rd_seen == LINES, "R2 read order", rd_seen, LINES);
        chk(lookup_err == 0, "R4 no lookup for invalid slot", lookup_err, 0);
        chk(got_wb_n == exp_wb_n, "R7 writeback count", got_wb_n, exp_wb_n);
        for (int k = 0; k < exp_wb_n && k < got_wb_n; k++)
            chk(got_wb[k] == exp_wb[k], "R7 writeback address", int'(got_wb[k]), int'(exp_wb[k]));
        chk(req_cyc == flushes * (delay + 2), "R7 request held until ack", req_cyc, flushes * (delay + 2));
        exp_busy = LINES + 3 + flushes * (delay + 3) - (last_flush ? 1 : 0);
        chk(busy_cyc == exp_busy, "R3 R11 R9 sweep length", busy_cyc, exp_busy);
        for (int i = 0; i < LINES; i++)
            chk(m_v[i] == keep[i], keep[i] ? "R5 line kept" :
                (m_d[i] ? "R7 dirty line moved" : "R4 R6 line cleared"),
                int'(m_v[i]), int'(keep[i]));
    endtask

    initial begin
        ack_delay = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en && !wb_req && !map_req,
            "R10 reset state", int'({busy, done, rd_en, wr_en, wb_req, map_req}), 0);
        sweep(0, 0, 0, 1'b0);
        sweep(1, 1, 0, 1'b0);
        sweep(2, 2, 0, 1'b0);
        sweep(5, 2, 3, 1'b1);
        sweep(4, 3, 1, 1'b0);
        sweep(9, 2, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", done_cyc, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule